// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This block collects single-cycle event pulses from four sources inside a display controller (end of a DMA frame fetch, a bus error, the start of vertical sync, and a pixel underrun). It keeps each source in a sticky raw status bit. Software sees the block through a simple word-addressed register port. It can read the raw bits, clear chosen bits by writing ones, choose which sources may interrupt, and read the raw status already filtered by that choice.

A single level-sensitive interrupt line is driven by a two-state machine. `LINE_QUIET` moves to `LINE_ACTIVE` on the `RAISE` transition, taken when the filtered set is non-empty. `LINE_ACTIVE` returns to `LINE_QUIET` on the `DROP` transition, taken when the filtered set is empty. The line is a register, so it follows the filtered set with one clock of latency. A read-only identity word sits at offset zero. Reads are combinational from the address.

Top module: `irq_status_unit`

## Requirements
- R1: Source bit positions are fixed: bit 0 end of frame fetch, bit 1 bus error, bit 2 vertical sync start, bit 3 pixel underrun. A high `evt_i[k]` at a clock edge sets raw bit k from the next cycle on, and the bit stays set until cleared.
- R2: Reading offset 0x10 returns the raw status in bits 3:0, with bits 31:4 zero.
- R3: A write to offset 0x14 clears every raw bit whose `reg_wdata` bit is one and leaves the other bits unchanged. Reading 0x14 returns zero.
- R4: Offset 0x18 holds the 4-bit mask. A write stores `reg_wdata[3:0]`, and the mask changes on no other access. A read returns it with bits 31:4 zero.
- R5: Reading offset 0x1C returns the raw status AND the mask.
- R6: `irq_o` is high in a cycle exactly when the masked status was non-empty in the previous cycle. The line rises when the set goes from empty to non-empty and falls when it becomes empty.
- R7: If a source pulses in the same cycle as a clear write that names its bit, the bit ends up set.
- R8: Offset 0x00 reads 0x1CDC0000: product field 0x1CDC in bits 31:16, major 0x00 in bits 15:8, minor 0x00 in bits 7:0.
- R9: Writes to 0x00, 0x10, 0x1C and to any undefined offset change no state. Reads of undefined offsets return zero.
- R10: After reset the raw status and the mask are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 4 | Event pulses, one per source |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for the current address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
An event pulse from a source and a software clear write can land in the same cycle. When both name the same bit, the two updates collide on that raw bit. The bench provokes this on purpose by pulsing a source while writing ones to the clear offset for that bit, and also for disjoint bits. It then reads the raw offset and expects the pulsed bit set and only the other named bits removed. A reference model that applies the clear before the set judges every cycle, and the same comparison covers mask writes that coincide with new events changing the interrupt line.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;

    // source bit positions
    localparam int SRC_FETCH_DONE = 0;
    localparam int SRC_BUS_FAULT  = 1;
    localparam int SRC_VSYNC      = 2;
    localparam int SRC_UNDERRUN   = 3;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_FILT   = 12'h01C;

    // identity fields
    localparam logic [15:0] ID_PRODUCT = 16'h1CDC;
    localparam logic [7:0]  ID_MAJOR   = 8'h00;
    localparam logic [7:0]  ID_MINOR   = 8'h00;
    localparam logic [DATA_W-1:0] ID_WORD = {ID_PRODUCT, ID_MAJOR, ID_MINOR};

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IDENT,
        SEL_RAW,
        SEL_CLEAR,
        SEL_ENABLE,
        SEL_FILT
    } reg_sel_e;

    typedef enum logic [0:0] {
        LINE_QUIET  = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    always_comb begin
        unique case (addr)
            AW'(OFS_IDENT):  sel = SEL_IDENT;
            AW'(OFS_RAW):    sel = SEL_RAW;
            AW'(OFS_CLEAR):  sel = SEL_CLEAR;
            AW'(OFS_ENABLE): sel = SEL_ENABLE;
            AW'(OFS_FILT):   sel = SEL_FILT;
            default:         sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] evt,
    input  logic          wr,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output logic [NS-1:0] raw,
    output logic [NS-1:0] mask
);
    logic clr_hit;
    logic en_hit;

    assign clr_hit = wr && (sel == SEL_CLEAR);
    assign en_hit  = wr && (sel == SEL_ENABLE);

    for (genvar k = 0; k < NS; k++) begin : g_src
        logic drop;
        assign drop = clr_hit && wdata[k];

        // a pulse beats a same-cycle clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                raw[k] <= 1'b0;
            end else if (evt[k]) begin
                raw[k] <= 1'b1;
            end else if (drop) begin
                raw[k] <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[k] <= 1'b0;
            end else if (en_hit) begin
                mask[k] <= wdata[k];
            end
        end
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int DW = DATA_W
) (
    input  reg_sel_e      sel,
    input  logic [NS-1:0] raw,
    input  logic [NS-1:0] mask,
    output logic [DW-1:0] rdata
);
    localparam int PAD = DW - NS;

    always_comb begin
        unique case (sel)
            SEL_IDENT:  rdata = ID_WORD;
            SEL_RAW:    rdata = {{PAD{1'b0}}, raw};
            SEL_ENABLE: rdata = {{PAD{1'b0}}, mask};
            SEL_FILT:   rdata = {{PAD{1'b0}}, raw & mask};
            SEL_CLEAR:  rdata = '0;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic line
);
    line_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending)  state_d = LINE_ACTIVE; // RAISE
            LINE_ACTIVE: if (!pending) state_d = LINE_QUIET;  // DROP
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LINE_ACTIVE: line = 1'b1;
            default:     line = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] evt_i,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_o
);
    reg_sel_e      sel;
    logic [NS-1:0] raw_q;
    logic [NS-1:0] mask_q;

    irq_addr_decode #(.AW(AW)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    irq_status_regs #(.NS(NS), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_i),
        .wr    (reg_wr),
        .sel   (sel),
        .wdata (reg_wdata),
        .raw   (raw_q),
        .mask  (mask_q)
    );

    irq_read_mux #(.NS(NS), .DW(DW)) u_rd (
        .sel   (sel),
        .raw   (raw_q),
        .mask  (mask_q),
        .rdata (reg_rdata)
    );

    irq_line_fsm u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|(raw_q & mask_q)),
        .line    (irq_o)
    );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NS-1:0] evt_i,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic [DW-1:0] reg_wdata,
    input logic          irq_o,
    input logic [NS-1:0] raw,
    input logic [NS-1:0] mask
);
    // R6
    line_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(raw & mask)));

    // R7
    pulse_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((raw & $past(evt_i)) == $past(evt_i)));

    // R3
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(OFS_CLEAR) && ((evt_i & reg_wdata[NS-1:0]) == '0))
        |=> ((raw & $past(reg_wdata[NS-1:0])) == '0));

    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(OFS_RAW) && evt_i == '0) |=> $stable(raw));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == AW'(OFS_ENABLE)) |=> $stable(mask));
endmodule

bind irq_status_unit irq_status_chk #(.NS(NS), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .raw       (raw_q),
    .mask      (mask_q)
);

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt_i = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int tests = 0;
    int fails = 0;
    string ctx = "R10";

    // behavioural reference state
    int m_raw = 0;
    int m_mask = 0;
    bit m_irq = 0;

    always #2 clk = ~clk;

    irq_status_unit dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_raw = 0; m_mask = 0; m_irq = 0;
        end else begin
            int nraw;
            m_irq = ((m_raw & m_mask) != 0);
            nraw = m_raw;
            if (reg_wr && reg_addr == 12'h014) nraw = nraw & ~int'(reg_wdata[3:0]);
            nraw = nraw | int'(evt_i);
            if (reg_wr && reg_addr == 12'h018) m_mask = int'(reg_wdata[3:0]);
            m_raw = nraw;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h000: return 32'h1CDC0000;         // R8
            12'h010: return 32'(m_raw);           // R2
            12'h018: return 32'(m_mask);          // R4
            12'h01C: return 32'(m_raw & m_mask);  // R5
            default: return 32'h0;                // R3 reads zero, R9
        endcase
    endfunction

    function automatic string addr_tag(input logic [11:0] a);
        case (a)
            12'h000: return "R8";
            12'h010: return "R2";
            12'h014: return "R3";
            12'h018: return "R4";
            12'h01C: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic compare();
        logic [31:0] e;
        e = exp_rd(reg_addr);
        tests++;
        if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s/%s addr=%h rdata actual=%h expected=%h",
                     ctx, addr_tag(reg_addr), reg_addr, reg_rdata, e);
        end
        tests++;
        if (irq_o !== m_irq) begin
            fails++;
            $display("FAIL %s/R6 irq_o actual=%0b expected=%0b", ctx, irq_o, m_irq);
        end
    endtask

    // sample at the falling edge, then drive the next inputs
    task automatic step(input logic [3:0] ev, input logic wr,
                        input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        compare();
        evt_i = ev; reg_wr = wr; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd(input logic [11:0] a);
        step(4'h0, 1'b0, a, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: state read back during and right after reset
        rd(12'h010); rd(12'h018);
        @(negedge clk); rst_n = 1'b1;
        rd(12'h010); rd(12'h018); rd(12'h01C);

        // R1: each source alone, read raw
        ctx = "R1";
        for (int k = 0; k < 4; k++) begin
            step(4'(1 << k), 1'b0, 12'h010, 32'h0);
            rd(12'h010);
            step(4'h0, 1'b1, 12'h014, 32'hF);
            rd(12'h010);
        end

        // R8 / R9 identity, undefined reads, read-only writes
        ctx = "R9";
        step(4'h5, 1'b0, 12'h000, 32'h0);
        rd(12'h000);
        step(4'h0, 1'b1, 12'h010, 32'hFFFF_FFFF);
        step(4'h0, 1'b1, 12'h01C, 32'h0);
        step(4'h0, 1'b1, 12'h000, 32'h0);
        step(4'h0, 1'b1, 12'h020, 32'hF);
        step(4'h0, 1'b1, 12'h004, 32'hF);
        rd(12'h010); rd(12'h018); rd(12'h020); rd(12'h014); rd(12'hFFC);

        // R4 / R5 / R6: mask drives the line
        ctx = "R6";
        step(4'h0, 1'b1, 12'h018, 32'hFFFF_FFF4);
        rd(12'h018); rd(12'h01C); rd(12'h01C);
        step(4'h0, 1'b1, 12'h018, 32'h0000_0002);
        rd(12'h01C); rd(12'h01C);
        step(4'h2, 1'b0, 12'h01C, 32'h0);
        rd(12'h01C); rd(12'h01C);
        step(4'h0, 1'b1, 12'h014, 32'h2);
        rd(12'h01C); rd(12'h01C);

        // R7: set against clear in the same cycle
        ctx = "R7";
        step(4'h0, 1'b1, 12'h018, 32'hF);
        step(4'hF, 1'b0, 12'h010, 32'h0);
        step(4'h8, 1'b1, 12'h014, 32'hC);
        rd(12'h010);
        step(4'h1, 1'b1, 12'h014, 32'h1);
        rd(12'h010);
        step(4'h0, 1'b1, 12'h014, 32'hF);
        rd(12'h010); rd(12'h010);

        // mixed traffic
        ctx = "R5";
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            int pick;
            pick = $urandom_range(0, 7);
            case (pick)
                0: a = 12'h000; 1: a = 12'h010; 2, 3: a = 12'h014;
                4, 5: a = 12'h018; 6: a = 12'h01C; default: a = 12'h024;
            endcase
            step(4'($urandom_range(0, 15) & $urandom_range(0, 15) & $urandom_range(0, 15)),
                 1'($urandom_range(0, 1)), a, $urandom());
        end
        rd(12'h010);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule